// File: doc/BRIEF.md
# Write-Through Snoop Coherence Controller

This block sits next to one core's write-through data cache and passively watches a shared bus on which every transfer has two phases. In the first phase an initiator presents a request. In the second phase the target memory acknowledges it. The controller acts only when a write from some other initiator completes inside the shared-memory window. In that case it looks up the cache tag for the written address. On a hit it does one of two things, chosen by a parameter: it clears the line's valid state (invalidate variant), or it overwrites the cached word with the bus write data (update variant).

The cache arrays are shared with the core through a mutual-exclusion lock held inside the block. The core raises a lock request and uses the arrays only while it holds the grant. The snoop takes the lock only for its tag compare and its invalidate or word-write cycle. A completed foreign write that finds the lock held by the core waits in a single pending register until the core lets go. Any core request that is refused shows up on a wait output as stall cycles.

The bus-monitor pins are plain sampled inputs with no back-pressure. The bus has at most one outstanding transfer. The cache must accept a lookup, an invalidate or a word write in the cycle it is strobed. The tag hit is a combinational answer to the lookup address.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: In the invalidate variant (UPDATE_MODE=0), a write that completes while `bus_req` and `bus_ack` are both high, from an initiator ID other than MY_ID, to an address in [REGION_BASE, REGION_LIMIT], and that hits in the tag lookup, clears the valid state of that line and leaves its tag and data unchanged.
- R2: In the update variant (UPDATE_MODE=1), the same event overwrites the hit line's word with the bus write data and leaves the line valid.
- R3: On a tag miss the cache is not modified. The lock is released in the cycle after the lookup, with no invalidate or word write following it.
- R4: Writes whose `bus_id` equals MY_ID never modify the cache.
- R5: Transfers with `bus_we`=0 (reads) never modify the cache.
- R6: Writes with an address below REGION_BASE or above REGION_LIMIT never modify the cache.
- R7: A request phase without acknowledge (`bus_req`=1, `bus_ack`=0) causes no lookup, however many cycles it lasts.
- R8: The lock is exclusive. `cl_lookup`, `cl_inv` and `cl_wr` are never high while `core_lock_gnt` is high. The core receives the grant in the cycle after it requests an idle lock, and keeps it while `core_lock_req` stays high.
- R9: A core request made while the snoop holds the lock is refused, and `core_wait` is high while it is refused. The grant follows once the snoop action ends.
- R10: A qualifying write that completes while the core holds the lock is kept, not dropped. Its action is performed after the core releases the lock.
- R11: After reset, `core_lock_gnt`, `core_wait`, `cl_lookup`, `cl_inv` and `cl_wr` are all low.
- R12: An action takes two cycles holding the lock. `cl_lookup` is high for one cycle. `cl_inv` or `cl_wr` is high only in the cycle directly after a lookup that hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request phase active |
| bus_ack | input | 1 | Target acknowledge; the transfer completes when it is high with bus_req |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_id | input | ID_W | Initiator ID of the current transfer |
| bus_addr | input | ADDR_W | Word address of the transfer |
| bus_wdata | input | DATA_W | Write data of the transfer |
| cl_lookup | output | 1 | Tag lookup strobe to the cache |
| cl_addr | output | ADDR_W | Address used for the lookup, invalidate and word write |
| cl_hit | input | 1 | Combinational tag-hit answer for cl_addr |
| cl_inv | output | 1 | Clear the valid state of the addressed line |
| cl_wr | output | 1 | Write cl_wdata into the addressed word |
| cl_wdata | output | DATA_W | Data for the word write |
| core_lock_req | input | 1 | Core asks for the cache lock |
| core_lock_gnt | output | 1 | Core holds the cache lock |
| core_wait | output | 1 | Core request refused this cycle (stall) |

## Verification
Every word address of a small configuration is swept, and each address is hit both with a matching tag and with a non-matching tag. Each address receives a foreign write, an own write and a foreign read, and both variants run side by side. A design that filtered on the wrong ID, the wrong region edge or the wrong transfer type would corrupt or stale a line at exactly those addresses. A request phase held without acknowledge catches a design that acts before completion. The lock is driven into contention in both directions. In one test the core holds the lock while a write completes, which exposes a dropped pending action or a snoop that writes under the core's grant. In the other the core asks while the snoop holds the lock, which exposes a missing stall or a grant that never returns.

// File: rtl/wts_pkg.sv
package wts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TAG  = 2'd2,
    ST_ACT  = 2'd3
  } seq_st_t;
endpackage

// File: rtl/wts_filter.sv
module wts_filter #(
  parameter int ADDR_W       = 16,
  parameter int ID_W         = 2,
  parameter int MY_ID        = 0,
  parameter int REGION_BASE  = 16'h4000,
  parameter int REGION_LIMIT = 16'h7FFF
) (
  input  logic              bus_req,
  input  logic              bus_ack,
  input  logic              bus_we,
  input  logic [ID_W-1:0]   bus_id,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              fire
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(REGION_BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(REGION_LIMIT);
  localparam logic [ID_W-1:0]   ME   = ID_W'(MY_ID);

  logic done_wr, foreign, in_win;

  assign done_wr = bus_req && bus_ack && bus_we;
  assign foreign = (bus_id != ME);
  assign in_win  = (bus_addr >= LO_A) && (bus_addr <= HI_A);
  assign fire    = done_wr && foreign && in_win;
endmodule

// File: rtl/wts_mutex.sv
module wts_mutex (
  input  logic clk,
  input  logic rst_n,
  input  logic core_lock_req,
  input  logic seq_idle,
  output logic core_hold,
  output logic core_wait
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              core_hold <= 1'b0;
    else if (!core_lock_req) core_hold <= 1'b0;
    else if (seq_idle)       core_hold <= 1'b1;
  end

  assign core_wait = core_lock_req && !core_hold;
endmodule

// File: rtl/wts_seq.sv
module wts_seq
  import wts_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              core_hold,
  input  logic              cl_hit,
  output logic              lookup,
  output logic              act,
  output logic              idle,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data
);
  seq_st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (fire) begin
          pend_addr <= bus_addr;
          pend_data <= bus_wdata;
          st        <= ST_WAIT;
        end
        ST_WAIT: if (!core_hold) st <= ST_TAG;
        ST_TAG:  st <= cl_hit ? ST_ACT : ST_IDLE;
        ST_ACT:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign lookup = (st == ST_TAG);
  assign act    = (st == ST_ACT);
  assign idle   = (st == ST_IDLE);
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int ID_W         = 2,
  parameter int MY_ID        = 0,
  parameter int REGION_BASE  = 16'h4000,
  parameter int REGION_LIMIT = 16'h7FFF,
  parameter int UPDATE_MODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_ack,
  input  logic              bus_we,
  input  logic [ID_W-1:0]   bus_id,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              cl_lookup,
  output logic [ADDR_W-1:0] cl_addr,
  input  logic              cl_hit,
  output logic              cl_inv,
  output logic              cl_wr,
  output logic [DATA_W-1:0] cl_wdata,
  input  logic              core_lock_req,
  output logic              core_lock_gnt,
  output logic              core_wait
);
  logic fire, seq_idle, core_hold, act;

  wts_filter #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .MY_ID(MY_ID),
    .REGION_BASE(REGION_BASE), .REGION_LIMIT(REGION_LIMIT)
  ) u_filter (
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
    .bus_id(bus_id), .bus_addr(bus_addr), .fire(fire)
  );

  wts_mutex u_mutex (
    .clk(clk), .rst_n(rst_n), .core_lock_req(core_lock_req),
    .seq_idle(seq_idle), .core_hold(core_hold), .core_wait(core_wait)
  );

  wts_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .core_hold(core_hold), .cl_hit(cl_hit),
    .lookup(cl_lookup), .act(act), .idle(seq_idle),
    .pend_addr(cl_addr), .pend_data(cl_wdata)
  );

  assign core_lock_gnt = core_hold;

  generate
    if (UPDATE_MODE != 0) begin : g_update
      assign cl_wr  = act;
      assign cl_inv = 1'b0;
    end else begin : g_invalidate
      assign cl_inv = act;
      assign cl_wr  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wts_checker.sv
module wts_checker (
  input logic clk,
  input logic rst_n,
  input logic cl_lookup,
  input logic cl_hit,
  input logic cl_inv,
  input logic cl_wr,
  input logic core_lock_req,
  input logic core_lock_gnt,
  input logic core_wait
);
  AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_lock_gnt && (cl_lookup || cl_inv || cl_wr))); // R8

  AST_ACT_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_inv || cl_wr) |-> $past(cl_lookup && cl_hit)); // R12

  AST_MISS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_lookup && !cl_hit) |=> !(cl_inv || cl_wr || cl_lookup)); // R3

  AST_CORE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (core_lock_req && cl_lookup) |-> core_wait); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cl_lookup, cl_inv, cl_wr})); // R12
endmodule

bind wt_snoop_ctrl wts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cl_lookup(cl_lookup), .cl_hit(cl_hit),
  .cl_inv(cl_inv), .cl_wr(cl_wr), .core_lock_req(core_lock_req),
  .core_lock_gnt(core_lock_gnt), .core_wait(core_wait)
);

// File: tb/wt_snoop_ctrl_tb.sv
module wt_snoop_ctrl_tb;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int ME = 1;
  localparam int LO = 8;
  localparam int HI = 47;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic bus_req = 0, bus_ack = 0, bus_we = 0;
  logic [1:0] bus_id = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0;
  logic core_lock_req = 0;

  logic lk [2];
  logic [AW-1:0] ca [2];
  logic hit [2];
  logic inv [2];
  logic wr [2];
  logic [DW-1:0] cwd [2];
  logic gnt [2];
  logic cw [2];

  logic c_val [2][4];
  logic [3:0] c_tag [2][4];
  logic [DW-1:0] c_dat [2][4];
  logic e_val [2][4];
  logic [3:0] e_tag [2][4];
  logic [DW-1:0] e_dat [2][4];

  wt_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ID_W(2), .MY_ID(ME),
    .REGION_BASE(LO), .REGION_LIMIT(HI), .UPDATE_MODE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_we(bus_we), .bus_id(bus_id), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cl_lookup(lk[0]), .cl_addr(ca[0]), .cl_hit(hit[0]), .cl_inv(inv[0]),
    .cl_wr(wr[0]), .cl_wdata(cwd[0]), .core_lock_req(core_lock_req),
    .core_lock_gnt(gnt[0]), .core_wait(cw[0]));

  wt_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ID_W(2), .MY_ID(ME),
    .REGION_BASE(LO), .REGION_LIMIT(HI), .UPDATE_MODE(1)) u_dut_upd (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_we(bus_we), .bus_id(bus_id), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cl_lookup(lk[1]), .cl_addr(ca[1]), .cl_hit(hit[1]), .cl_inv(inv[1]),
    .cl_wr(wr[1]), .cl_wdata(cwd[1]), .core_lock_req(core_lock_req),
    .core_lock_gnt(gnt[1]), .core_wait(cw[1]));

  // behavioural cache: direct mapped, 4 one-word lines, index = addr[1:0], tag = addr[5:2]
  assign hit[0] = c_val[0][ca[0][1:0]] && (c_tag[0][ca[0][1:0]] == ca[0][5:2]);
  assign hit[1] = c_val[1][ca[1][1:0]] && (c_tag[1][ca[1][1:0]] == ca[1][5:2]);

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (inv[m]) c_val[m][ca[m][1:0]] <= 1'b0;
      if (wr[m])  c_dat[m][ca[m][1:0]] <= cwd[m];
    end
  end

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [147:0] act, input logic [147:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [147:0] pack_c(input int m);
    logic [147:0] v;
    for (int i = 0; i < 4; i++) v[i*37 +: 37] = {c_val[m][i], c_tag[m][i], c_dat[m][i]};
    return v;
  endfunction

  function automatic logic [147:0] pack_e(input int m);
    logic [147:0] v;
    for (int i = 0; i < 4; i++) v[i*37 +: 37] = {e_val[m][i], e_tag[m][i], e_dat[m][i]};
    return v;
  endfunction

  task automatic preload(input int a, input bit hitsel);
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 4; i++) begin
        c_val[m][i] = 1'b1;
        c_tag[m][i] = 4'((i * 5 + a) & 15);
        c_dat[m][i] = 32'hC0DE_0000 | 32'(a * 4 + i);
        if (i == (a & 3)) c_tag[m][i] = hitsel ? 4'(a >> 2) : 4'((a >> 2) ^ 1);
        e_val[m][i] = c_val[m][i];
        e_tag[m][i] = c_tag[m][i];
        e_dat[m][i] = c_dat[m][i];
      end
  endtask

  task automatic bus_xfer(input int a, input bit we, input int id, input logic [DW-1:0] d);
    bus_req = 1; bus_we = we; bus_id = 2'(id); bus_addr = AW'(a); bus_wdata = d; bus_ack = 0;
    @(negedge clk);
    bus_ack = 1;
    @(negedge clk);
    bus_req = 0; bus_ack = 0; bus_we = 0;
  endtask

  task automatic expect_apply(input int a, input bit we, input int id, input logic [DW-1:0] d);
    int ix;
    ix = a & 3;
    if (we && id != ME && a >= LO && a <= HI && e_tag[0][ix] == 4'(a >> 2) && e_val[0][ix]) begin
      e_val[0][ix] = 1'b0;
      e_dat[1][ix] = d;
    end
  endtask

  task automatic cmp_both(input string t0, input string t1);
    check(pack_c(0) == pack_e(0), t0, pack_c(0), pack_e(0));
    check(pack_c(1) == pack_e(1), t1, pack_c(1), pack_e(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    for (int m = 0; m < 2; m++)
      check(!gnt[m] && !cw[m] && !lk[m] && !inv[m] && !wr[m], "R11",
            148'({gnt[m], cw[m], lk[m], inv[m], wr[m]}), 148'(0));

    // sweep every address, every transfer kind, hit and miss
    for (int a = 0; a < 64; a++)
      for (int k = 0; k < 3; k++)
        for (int h = 0; h < 2; h++) begin
          logic [DW-1:0] d;
          bit we;
          int id;
          string t0, t1;
          d  = 32'h5A00_0000 | 32'(a * 8 + k * 2 + h);
          we = (k != 2);
          id = (k == 1) ? ME : ((a % 3 == 0) ? 0 : ((a % 3 == 1) ? 2 : 3));
          preload(a, h[0]);
          @(negedge clk);
          bus_xfer(a, we, id, d);
          expect_apply(a, we, id, d);
          repeat (6) @(negedge clk);
          if (k == 1)                 begin t0 = "R4"; t1 = "R4"; end
          else if (k == 2)            begin t0 = "R5"; t1 = "R5"; end
          else if (a < LO || a > HI)  begin t0 = "R6"; t1 = "R6"; end
          else if (h == 0)            begin t0 = "R3"; t1 = "R3"; end
          else                        begin t0 = "R1"; t1 = "R2"; end
          cmp_both(t0, t1);
        end

    // R7: long request phase without acknowledge
    preload(20, 1);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_id = 0; bus_addr = 20; bus_wdata = 32'hAAAA_5555;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(!lk[0] && !lk[1], "R7", 148'({lk[0], lk[1]}), 148'(0));
    end
    bus_ack = 1;
    @(negedge clk);
    bus_req = 0; bus_ack = 0; bus_we = 0;
    expect_apply(20, 1, 0, 32'hAAAA_5555);
    repeat (6) @(negedge clk);
    cmp_both("R7", "R7");

    // R8 / R10: core holds the lock while a foreign write completes
    preload(33, 1);
    core_lock_req = 1;
    @(negedge clk);
    check(gnt[0] && gnt[1] && !cw[0], "R8", 148'({gnt[0], gnt[1], cw[0]}), 148'(3'b110));
    bus_xfer(33, 1, 2, 32'h1234_9876);
    repeat (10) @(negedge clk);
    check(!lk[0] && !lk[1], "R8", 148'({lk[0], lk[1]}), 148'(0));
    cmp_both("R10", "R10");
    core_lock_req = 0;
    expect_apply(33, 1, 2, 32'h1234_9876);
    repeat (6) @(negedge clk);
    cmp_both("R10", "R10");

    // R9: core asks while the snoop holds the lock
    preload(26, 1);
    @(negedge clk);
    bus_xfer(26, 1, 3, 32'hFEED_0026);
    core_lock_req = 1;
    @(negedge clk);
    check(cw[0] && cw[1] && !gnt[0] && !gnt[1], "R9",
          148'({cw[0], cw[1], gnt[0], gnt[1]}), 148'(4'b1100));
    repeat (4) @(negedge clk);
    check(gnt[0] && gnt[1] && !cw[0] && !cw[1], "R9",
          148'({cw[0], cw[1], gnt[0], gnt[1]}), 148'(4'b0011));
    expect_apply(26, 1, 3, 32'hFEED_0026);
    cmp_both("R9", "R9");
    core_lock_req = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule